// File: doc/BRIEF.md
# Stack Execution Core

This block runs already-decoded instructions on a small register state: an instruction pointer, a stack pointer, a frame pointer, a flag word and two general registers, each 32 bits wide. Every record it accepts carries an opcode, a two-bit operand kind, a destination register index, an operand value and the instruction's byte length. The block resolves the second operand, from the record itself, from a register or from memory. It then performs one of the arithmetic, logic, shift, compare, load, stack or control-transfer operations and advances or redirects the instruction pointer.

Records come in over a valid/ready handshake, one at a time. Memory is reached through a single port that answers a read in the cycle after the request. After every completed record the block emits a one-cycle completion pulse. Alongside the pulse it shows the register write it made, the resulting instruction pointer, stack pointer and flags, and a divide error indication. A front end feeds it records, and a bench or trace unit follows progress on the completion outputs.

Top module: `stk_exec_core`

## Requirements
- R1: After reset the instruction pointer is 0, the stack pointer is STACK_TOP (256 by default), the flags are 0, `in_ready` is high, and neither `mem_req` nor `done_valid` is asserted.
- R2: The second operand is chosen by `in_kind`: 00 uses `in_val` itself, 01 uses the register indexed by `in_val[2:0]`, 10 reads the memory word at address `in_val`, and 11 reads the memory word at the address held in the register indexed by `in_val[2:0]`. Register indices are 0 ip, 1 sp, 2 fp, 3 flags, 4 and 5 general.
- R3: Opcodes 2 add, 3 sub, 4 mul (low word), 5 unsigned div, 6 and, 7 or, 8 xor and 9 shl write (register `in_reg`) op (second operand) back into register `in_reg`. A shift uses the low five bits of the operand as its amount.
- R4: Flag bit 0 (zero) is set by every ALU operation and by compare (opcode 0xC) when the result is zero. Flag bit 1 (carry) is taken from the carry out of add, the borrow of sub and compare, and the last bit shifted out by shl. The other ALU operations keep carry. Compare writes no register, and flags change only when an instruction completes.
- R5: Opcode 0xA writes the second operand into register `in_reg`. Opcode 0xB stores register `in_reg` to the address `in_val` (kinds 00/10) or to the address held in register `in_val[2:0]` (kinds 01/11), and it never reads memory.
- R6: Push (opcode 0) first lowers sp by 4 and then stores the operand at the new sp. Pop (opcode 1) reads the word at sp into register `in_val[2:0]` and then raises sp by 4. The stack pointer changes only when an instruction completes.
- R7: Opcode 0xD always jumps. 0xF jumps when zero is set, 0x10 when carry is set, and 0xE when both are clear. A taken jump loads the second operand into ip; a jump that is not taken advances ip by the length.
- R8: Call (opcode 0x11) pushes the address of the next instruction (ip plus length) the same way as push and then jumps to the second operand. Return (opcode 0x12) pops the top stack word into ip.
- R9: A divide by zero leaves the destination and the flags unchanged and raises `done_err` together with that record's `done_valid`.
- R10: Every other instruction, nop (0x13) included, advances ip by `in_len`. A register write that names ip takes priority over the advance, and ip changes only when an instruction completes.
- R11: `in_ready` is high only while no record is in progress; it drops in the cycle after a handshake, and each accepted record produces exactly one `done_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Record offered |
| in_ready | output | 1 | Block idle, record taken on valid and ready |
| in_op | input | 5 | Opcode |
| in_kind | input | 2 | Second operand kind |
| in_reg | input | 3 | First operand register index |
| in_val | input | W | Second operand value, register index or address |
| in_len | input | LEN_W | Instruction byte length |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Byte address |
| mem_wdata | output | W | Write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |
| done_valid | output | 1 | One-cycle completion pulse |
| done_wr | output | 1 | Completed record wrote a register |
| done_idx | output | 3 | Index of the register written |
| done_data | output | W | Value written |
| done_err | output | 1 | Divide by zero on this record |
| done_ip | output | W | Instruction pointer |
| done_sp | output | W | Stack pointer |
| done_flags | output | 2 | Flags: bit 1 carry, bit 0 zero |

## Verification
The bench goes after carry at its edges: a subtraction that borrows to all ones, an add that wraps to zero with carry set, and a shift whose last bit out is one. A design that read the wrong carry bit or cleared carry on the other ALU operations would put the wrong flags on the completion outputs and send the conditional jumps the wrong way. The stack order is checked by pushes read back through pops and by a call/return pair. A design that stored before decrementing, or incremented before loading, would return the wrong word or leave sp off by four. A divide by zero must leave its register untouched, a write to ip must beat the length advance, and a compare must write nothing. Errors in any of these show up as a wrong write flag, index or ip.

// File: rtl/stk_pkg.sv
package stk_pkg;

   typedef enum logic [4:0] {
      OP_PUSH = 5'h00, OP_POP  = 5'h01, OP_ADD  = 5'h02, OP_SUB  = 5'h03,
      OP_MUL  = 5'h04, OP_DIV  = 5'h05, OP_AND  = 5'h06, OP_OR   = 5'h07,
      OP_XOR  = 5'h08, OP_SHL  = 5'h09, OP_LDR  = 5'h0A, OP_LDM  = 5'h0B,
      OP_CMP  = 5'h0C, OP_JMP  = 5'h0D, OP_JG   = 5'h0E, OP_JZ   = 5'h0F,
      OP_JL   = 5'h10, OP_CALL = 5'h11, OP_RET  = 5'h12, OP_NOP  = 5'h13
   } op_e;

   typedef enum logic [1:0] {
      K_IMM = 2'b00, K_REG = 2'b01, K_MIMM = 2'b10, K_MREG = 2'b11
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RD, ST_LAT, ST_EXEC, ST_POP
   } st_e;

   localparam int RIDX_W = 3;
   localparam int R_IP   = 0;
   localparam int R_SP   = 1;
   localparam int R_FP   = 2;
   localparam int R_FL   = 3;
   localparam int R_G0   = 4;
   localparam int R_G1   = 5;
   localparam int NREG   = 6;
   localparam int ZBIT   = 0;
   localparam int CBIT   = 1;

endpackage

// File: rtl/stk_alu.sv
module stk_alu
   import stk_pkg::*;
#(
   parameter int W       = 32,
   parameter bit HAS_DIV = 1'b1
) (
   input  op_e          op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         c_in,
   output logic [W-1:0] res,
   output logic         z,
   output logic         c,
   output logic         writes,
   output logic         upd,
   output logic         div_err
);

   localparam int SH_W = $clog2(W);

   logic [W:0]   sum, dif, shx;
   logic [W-1:0] quo;
   logic         div_ok;

   generate
      if (HAS_DIV) begin : g_div
         assign div_ok = (b != '0);
         assign quo    = div_ok ? (a / b) : '0;
      end else begin : g_nodiv
         assign div_ok = 1'b0;
         assign quo    = '0;
      end
   endgenerate

   assign sum = {1'b0, a} + {1'b0, b};
   assign dif = {1'b0, a} - {1'b0, b};
   assign shx = {1'b0, a} << b[SH_W-1:0];

   always_comb begin
      res     = a;
      c       = c_in;
      writes  = 1'b0;
      upd     = 1'b0;
      div_err = 1'b0;
      unique case (op)
         OP_ADD: begin res = sum[W-1:0]; c = sum[W]; writes = 1'b1; upd = 1'b1; end
         OP_SUB: begin res = dif[W-1:0]; c = dif[W]; writes = 1'b1; upd = 1'b1; end
         OP_CMP: begin res = dif[W-1:0]; c = dif[W]; upd = 1'b1; end
         OP_MUL: begin res = a * b; writes = 1'b1; upd = 1'b1; end
         OP_DIV: begin
            if (div_ok) begin
               res = quo; writes = 1'b1; upd = 1'b1;
            end else begin
               div_err = 1'b1;
            end
         end
         OP_AND: begin res = a & b; writes = 1'b1; upd = 1'b1; end
         OP_OR:  begin res = a | b; writes = 1'b1; upd = 1'b1; end
         OP_XOR: begin res = a ^ b; writes = 1'b1; upd = 1'b1; end
         OP_SHL: begin res = shx[W-1:0]; c = shx[W]; writes = 1'b1; upd = 1'b1; end
         default: ;
      endcase
      z = (res == '0);
   end

endmodule

// File: rtl/stk_regs.sv
module stk_regs
   import stk_pkg::*;
#(
   parameter int          W         = 32,
   parameter int unsigned STACK_TOP = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIDX_W-1:0] ra_idx,
   input  logic [RIDX_W-1:0] rb_idx,
   output logic [W-1:0]      ra,
   output logic [W-1:0]      rb,
   input  logic              gw_en,
   input  logic [RIDX_W-1:0] gw_idx,
   input  logic [W-1:0]      gw_d,
   input  logic              ip_en,
   input  logic [W-1:0]      ip_d,
   input  logic              sp_en,
   input  logic [W-1:0]      sp_d,
   input  logic              fl_en,
   input  logic [1:0]        fl_d,
   output logic [W-1:0]      ip_o,
   output logic [W-1:0]      sp_o,
   output logic [1:0]        fl_o
);

   localparam logic [RIDX_W-1:0] NREG_L = RIDX_W'(NREG);

   generate
      if (NREG > (1 << RIDX_W)) begin : g_chk_idx
         $error("register count exceeds index range");
      end
      if (W < 8) begin : g_chk_w
         $error("register width too small");
      end
   endgenerate

   logic [W-1:0] q [NREG];

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_reg
         localparam logic [W-1:0] RV = (g == R_SP) ? W'(STACK_TOP) : '0;
         logic [W-1:0] r;
         logic         sen;
         logic [W-1:0] sd;

         if (g == R_IP) begin : g_ip
            assign sen = ip_en;
            assign sd  = ip_d;
         end else if (g == R_SP) begin : g_sp
            assign sen = sp_en;
            assign sd  = sp_d;
         end else if (g == R_FL) begin : g_fl
            assign sen = fl_en;
            assign sd  = {r[W-1:2], fl_d};
         end else begin : g_gen
            assign sen = 1'b0;
            assign sd  = '0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               r <= RV;
            else if (gw_en && gw_idx == RIDX_W'(g))
               r <= gw_d;
            else if (sen)
               r <= sd;
         end

         assign q[g] = r;
      end
   endgenerate

   assign ra   = (ra_idx < NREG_L) ? q[ra_idx] : '0;
   assign rb   = (rb_idx < NREG_L) ? q[rb_idx] : '0;
   assign ip_o = q[R_IP];
   assign sp_o = q[R_SP];
   assign fl_o = q[R_FL][1:0];

endmodule

// File: rtl/stk_exec_core.sv
module stk_exec_core
   import stk_pkg::*;
#(
   parameter int          W         = 32,
   parameter int          LEN_W     = 5,
   parameter int unsigned STACK_TOP = 256,
   parameter bit          HAS_DIV   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [4:0]        in_op,
   input  logic [1:0]        in_kind,
   input  logic [2:0]        in_reg,
   input  logic [W-1:0]      in_val,
   input  logic [LEN_W-1:0]  in_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic [W-1:0]      mem_addr,
   output logic [W-1:0]      mem_wdata,
   input  logic [W-1:0]      mem_rdata,
   output logic              done_valid,
   output logic              done_wr,
   output logic [2:0]        done_idx,
   output logic [W-1:0]      done_data,
   output logic              done_err,
   output logic [W-1:0]      done_ip,
   output logic [W-1:0]      done_sp,
   output logic [1:0]        done_flags
);

   localparam int           STEP   = W / 8;
   localparam logic [W-1:0] STEP_W = W'(STEP);

   generate
      if (W % 8 != 0) begin : g_chk_bytes
         $error("register width must be whole bytes");
      end
      if (LEN_W > W) begin : g_chk_len
         $error("length field wider than registers");
      end
      if (STACK_TOP % STEP != 0) begin : g_chk_top
         $error("stack top not aligned to register size");
      end
   endgenerate

   st_e                st;
   op_e                op_q;
   kind_e              kind_q;
   logic [2:0]         reg_q;
   logic [W-1:0]       val_q, opb_q;
   logic [LEN_W-1:0]   len_q;

   logic [RIDX_W-1:0]  rb_idx;
   logic [W-1:0]       ra, rb, ip, sp;
   logic [1:0]         fl;

   logic               gw_en, ip_en, sp_en, fl_en;
   logic [RIDX_W-1:0]  gw_idx;
   logic [W-1:0]       gw_d, ip_d, sp_d;
   logic [1:0]         fl_d;

   logic [W-1:0]       alu_res;
   logic               alu_z, alu_c, alu_wr, alu_upd, alu_err;

   logic               accept, need_rd, commit;
   logic [W-1:0]       next_ip, sp_dn, sp_up;

   logic               dv_q, dw_q, de_q;
   logic [2:0]         di_q;
   logic [W-1:0]       dd_q;

   assign in_ready = (st == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign need_rd  = in_kind[1] && (op_e'(in_op) != OP_LDM);
   assign rb_idx   = (st == ST_IDLE) ? in_val[2:0] : val_q[2:0];

   stk_regs #(.W(W), .STACK_TOP(STACK_TOP)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(reg_q), .rb_idx(rb_idx), .ra(ra), .rb(rb),
      .gw_en(gw_en), .gw_idx(gw_idx), .gw_d(gw_d),
      .ip_en(ip_en), .ip_d(ip_d),
      .sp_en(sp_en), .sp_d(sp_d),
      .fl_en(fl_en), .fl_d(fl_d),
      .ip_o(ip), .sp_o(sp), .fl_o(fl)
   );

   stk_alu #(.W(W), .HAS_DIV(HAS_DIV)) u_alu (
      .op(op_q), .a(ra), .b(opb_q), .c_in(fl[CBIT]),
      .res(alu_res), .z(alu_z), .c(alu_c),
      .writes(alu_wr), .upd(alu_upd), .div_err(alu_err)
   );

   assign next_ip = ip + W'(len_q);
   assign sp_dn   = sp - STEP_W;
   assign sp_up   = sp + STEP_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_NOP;
         kind_q <= K_IMM;
         reg_q  <= '0;
         val_q  <= '0;
         opb_q  <= '0;
         len_q  <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (accept) begin
               op_q   <= op_e'(in_op);
               kind_q <= kind_e'(in_kind);
               reg_q  <= in_reg;
               val_q  <= in_val;
               len_q  <= in_len;
               if (need_rd) begin
                  st <= ST_RD;
               end else begin
                  opb_q <= in_kind[0] ? rb : in_val;
                  st    <= ST_EXEC;
               end
            end
            ST_RD:   st <= ST_LAT;
            ST_LAT:  begin opb_q <= mem_rdata; st <= ST_EXEC; end
            ST_EXEC: st <= (op_q == OP_POP || op_q == OP_RET) ? ST_POP : ST_IDLE;
            ST_POP:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      gw_en     = 1'b0;
      gw_idx    = reg_q;
      gw_d      = '0;
      sp_en     = 1'b0;
      sp_d      = sp;
      fl_en     = 1'b0;
      fl_d      = fl;
      ip_d      = next_ip;
      commit    = 1'b0;
      unique case (st)
         ST_RD: begin
            mem_req  = 1'b1;
            mem_addr = kind_q[0] ? rb : val_q;
         end
         ST_EXEC: begin
            commit = 1'b1;
            unique case (op_q)
               OP_PUSH: begin
                  mem_req = 1'b1; mem_we = 1'b1;
                  mem_addr = sp_dn; mem_wdata = opb_q;
                  sp_en = 1'b1; sp_d = sp_dn;
               end
               OP_POP, OP_RET: begin
                  commit   = 1'b0;
                  mem_req  = 1'b1;
                  mem_addr = sp;
               end
               OP_LDR: begin gw_en = 1'b1; gw_d = opb_q; end
               OP_LDM: begin
                  mem_req = 1'b1; mem_we = 1'b1;
                  mem_addr = opb_q; mem_wdata = ra;
               end
               OP_JMP: ip_d = opb_q;
               OP_JZ:  ip_d = fl[ZBIT] ? opb_q : next_ip;
               OP_JL:  ip_d = fl[CBIT] ? opb_q : next_ip;
               OP_JG:  ip_d = (!fl[ZBIT] && !fl[CBIT]) ? opb_q : next_ip;
               OP_CALL: begin
                  mem_req = 1'b1; mem_we = 1'b1;
                  mem_addr = sp_dn; mem_wdata = next_ip;
                  sp_en = 1'b1; sp_d = sp_dn;
                  ip_d = opb_q;
               end
               OP_NOP: ;
               default: begin
                  gw_en = alu_wr;
                  gw_d  = alu_res;
                  fl_en = alu_upd;
                  fl_d  = {alu_c, alu_z};
               end
            endcase
         end
         ST_POP: begin
            commit = 1'b1;
            sp_en  = 1'b1;
            sp_d   = sp_up;
            if (op_q == OP_RET) begin
               ip_d = mem_rdata;
            end else begin
               gw_en  = 1'b1;
               gw_idx = val_q[2:0];
               gw_d   = mem_rdata;
            end
         end
         default: ;
      endcase
   end

   assign ip_en = commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dv_q <= 1'b0;
         dw_q <= 1'b0;
         de_q <= 1'b0;
         di_q <= '0;
         dd_q <= '0;
      end else begin
         dv_q <= commit;
         dw_q <= commit && gw_en;
         de_q <= commit && (st == ST_EXEC) && alu_err;
         if (commit && gw_en) begin
            di_q <= gw_idx;
            dd_q <= gw_d;
         end
      end
   end

   assign done_valid = dv_q;
   assign done_wr    = dw_q;
   assign done_err   = de_q;
   assign done_idx   = di_q;
   assign done_data  = dd_q;
   assign done_ip    = ip;
   assign done_sp    = sp;
   assign done_flags = fl;

endmodule

// File: rtl/stk_exec_core_chk.sv
module stk_exec_core_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         in_valid,
   input logic         in_ready,
   input logic         mem_req,
   input logic         mem_we,
   input logic         done_valid,
   input logic         done_err,
   input logic [W-1:0] done_ip,
   input logic [W-1:0] done_sp,
   input logic [1:0]   done_flags
);

   assert_ready_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_err |-> done_valid);

   assert_ip_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_valid |-> $stable(done_ip));

   assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !done_valid |-> $stable(done_flags));

   assert_sp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_valid |-> $stable(done_sp));

   assert_write_is_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_req);

endmodule

bind stk_exec_core stk_exec_core_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .mem_req(mem_req), .mem_we(mem_we), .done_valid(done_valid),
   .done_err(done_err), .done_ip(done_ip), .done_sp(done_sp),
   .done_flags(done_flags)
);

// File: tb/stk_exec_core_tb.sv
module stk_exec_core_tb;
   import stk_pkg::*;

   typedef struct {
      logic [31:0] ip;
      logic [31:0] sp;
      logic [1:0]  fl;
      logic        wr;
      logic [2:0]  idx;
      logic [31:0] data;
      logic        err;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [4:0]  in_op = '0;
   logic [1:0]  in_kind = '0;
   logic [2:0]  in_reg = '0;
   logic [31:0] in_val = '0;
   logic [4:0]  in_len = '0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        done_valid, done_wr, done_err;
   logic [2:0]  done_idx;
   logic [31:0] done_data, done_ip, done_sp;
   logic [1:0]  done_flags;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] e_mem [64];
   logic [31:0] m_mem [64];
   logic [31:0] m_reg [6];
   exp_t        q [$];
   exp_t        cur;

   always #2 clk = ~clk;

   stk_exec_core u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_kind(in_kind), .in_reg(in_reg), .in_val(in_val),
      .in_len(in_len), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done_valid(done_valid), .done_wr(done_wr), .done_idx(done_idx),
      .done_data(done_data), .done_err(done_err), .done_ip(done_ip),
      .done_sp(done_sp), .done_flags(done_flags)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we) e_mem[mem_addr[7:2]] <= mem_wdata;
      if (mem_req && !mem_we) mem_rdata <= e_mem[mem_addr[7:2]];
   end

   task automatic check(input bit ok, input string msg);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s", msg);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && done_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R11 completion with no record pending: got 1 expected 0");
         end else begin
            cur = q.pop_front();
            check(done_ip == cur.ip && done_sp == cur.sp && done_flags == cur.fl &&
                  done_err == cur.err && done_wr == cur.wr &&
                  (!cur.wr || (done_idx == cur.idx && done_data == cur.data)),
                  $sformatf("%s: got ip=%h sp=%h fl=%b err=%b wr=%b idx=%0d data=%h expected ip=%h sp=%h fl=%b err=%b wr=%b idx=%0d data=%h",
                            cur.tag, done_ip, done_sp, done_flags, done_err, done_wr, done_idx, done_data,
                            cur.ip, cur.sp, cur.fl, cur.err, cur.wr, cur.idx, cur.data));
         end
      end
   end

   function automatic logic [31:0] rdr(input logic [2:0] i);
      return (i < 3'd6) ? m_reg[i] : 32'h0;
   endfunction

   task automatic issue(input op_e op, input logic [1:0] k, input logic [2:0] rg,
                        input logic [31:0] v, input logic [4:0] ln, input string tag);
      exp_t        e;
      logic [31:0] a, b, nip, r, t32;
      logic [32:0] t;
      logic        c, z, err, wr;
      a   = rdr(rg);
      nip = m_reg[0] + 32'(ln);
      t32 = rdr(v[2:0]);
      case (k)
         2'b00: b = v;
         2'b01: b = t32;
         2'b10: b = m_mem[v[7:2]];
         default: b = m_mem[t32[7:2]];
      endcase
      if (op == OP_LDM) b = k[0] ? t32 : v;
      e.wr = 1'b0; e.idx = '0; e.data = '0; e.err = 1'b0; e.tag = tag;
      c = m_reg[3][1]; r = a; err = 1'b0; wr = 1'b0;
      m_reg[0] = nip;
      case (op)
         OP_PUSH: begin m_reg[1] = m_reg[1] - 4; m_mem[m_reg[1][7:2]] = b; end
         OP_POP: begin
            r = m_mem[m_reg[1][7:2]];
            m_reg[1] = m_reg[1] + 4;
            e.wr = 1'b1; e.idx = v[2:0]; e.data = r;
            if (v[2:0] < 3'd6) m_reg[v[2:0]] = r;
         end
         OP_LDR: begin e.wr = 1'b1; e.idx = rg; e.data = b; m_reg[rg] = b; end
         OP_LDM: m_mem[b[7:2]] = a;
         OP_JMP: m_reg[0] = b;
         OP_JZ:  if (m_reg[3][0]) m_reg[0] = b;
         OP_JL:  if (m_reg[3][1]) m_reg[0] = b;
         OP_JG:  if (!m_reg[3][0] && !m_reg[3][1]) m_reg[0] = b;
         OP_CALL: begin m_reg[1] = m_reg[1] - 4; m_mem[m_reg[1][7:2]] = nip; m_reg[0] = b; end
         OP_RET: begin m_reg[0] = m_mem[m_reg[1][7:2]]; m_reg[1] = m_reg[1] + 4; end
         OP_NOP: ;
         default: begin
            wr = (op != OP_CMP);
            case (op)
               OP_ADD: begin t = {1'b0, a} + {1'b0, b}; r = t[31:0]; c = t[32]; end
               OP_SUB, OP_CMP: begin t = {1'b0, a} - {1'b0, b}; r = t[31:0]; c = t[32]; end
               OP_MUL: r = a * b;
               OP_DIV: if (b == 0) begin err = 1'b1; wr = 1'b0; end else r = a / b;
               OP_AND: r = a & b;
               OP_OR:  r = a | b;
               OP_XOR: r = a ^ b;
               OP_SHL: begin t = {1'b0, a} << b[4:0]; r = t[31:0]; c = t[32]; end
               default: ;
            endcase
            if (!err) begin
               z = (r == 0);
               m_reg[3][1:0] = {c, z};
            end
            e.err = err;
            if (wr) begin e.wr = 1'b1; e.idx = rg; e.data = r; m_reg[rg] = r; end
         end
      endcase
      e.ip = m_reg[0]; e.sp = m_reg[1]; e.fl = m_reg[3][1:0];
      q.push_back(e);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_kind = k; in_reg = rg; in_val = v; in_len = ln;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check(!in_ready, $sformatf("R11 ready after handshake: got %b expected 0", in_ready));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) begin
         e_mem[i] = 32'h1000 + 32'(i) * 3;
         m_mem[i] = 32'h1000 + 32'(i) * 3;
      end
      for (int i = 0; i < 6; i++) m_reg[i] = 0;
      m_reg[1] = 32'd256;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(in_ready && !mem_req && !done_valid && done_ip == 0 && done_sp == 256 && done_flags == 0,
            $sformatf("R1 reset state: got rdy=%b req=%b dv=%b ip=%h sp=%h fl=%b expected 1 0 0 0 100 00",
                      in_ready, mem_req, done_valid, done_ip, done_sp, done_flags));
      rst_n = 1'b1;
      @(negedge clk);
      check(done_ip == 0 && done_sp == 256 && in_ready,
            $sformatf("R1 after release: got ip=%h sp=%h expected 0 100", done_ip, done_sp));

      issue(OP_LDR, 2'b00, 3'd4, 32'd5, 5'd6, "R5 R2 load imm");
      issue(OP_LDR, 2'b00, 3'd5, 32'd7, 5'd6, "R5 load imm gr1");
      issue(OP_ADD, 2'b01, 3'd4, 32'd5, 5'd3, "R3 R2 add reg");
      issue(OP_SUB, 2'b00, 3'd4, 32'd12, 5'd4, "R4 sub to zero");
      issue(OP_SUB, 2'b00, 3'd4, 32'd1, 5'd4, "R4 sub borrow");
      issue(OP_MUL, 2'b00, 3'd4, 32'd1, 5'd4, "R4 mul keeps carry");
      issue(OP_ADD, 2'b00, 3'd4, 32'd1, 5'd4, "R4 add wraps carry zero");
      issue(OP_LDR, 2'b10, 3'd5, 32'h10, 5'd4, "R2 mem imm");
      issue(OP_LDR, 2'b00, 3'd2, 32'h20, 5'd4, "R5 load fp");
      issue(OP_LDR, 2'b11, 3'd5, 32'd2, 5'd3, "R2 mem reg");
      issue(OP_LDR, 2'b00, 3'd4, 32'h0000ABCD, 5'd4, "R5 load value");
      issue(OP_LDM, 2'b00, 3'd4, 32'h40, 5'd4, "R5 store imm address");
      issue(OP_LDR, 2'b10, 3'd5, 32'h40, 5'd4, "R5 read back store");
      issue(OP_LDM, 2'b11, 3'd5, 32'd2, 5'd3, "R5 store reg address no read");
      issue(OP_LDR, 2'b10, 3'd4, 32'h20, 5'd4, "R5 read back reg store");
      issue(OP_LDR, 2'b00, 3'd4, 32'h18000000, 5'd6, "R3 load shift value");
      issue(OP_SHL, 2'b00, 3'd4, 32'd4, 5'd3, "R4 shl carry out");
      issue(OP_SHL, 2'b00, 3'd4, 32'd0, 5'd3, "R4 shl by zero");
      issue(OP_AND, 2'b00, 3'd4, 32'hF0000000, 5'd3, "R3 and");
      issue(OP_OR,  2'b00, 3'd4, 32'h0000000F, 5'd3, "R3 or");
      issue(OP_XOR, 2'b01, 3'd4, 32'd4, 5'd3, "R3 xor self zero");
      issue(OP_LDR, 2'b00, 3'd4, 32'd100, 5'd4, "R5 load dividend");
      issue(OP_DIV, 2'b00, 3'd4, 32'd0, 5'd3, "R9 divide by zero");
      issue(OP_DIV, 2'b00, 3'd4, 32'd7, 5'd3, "R3 divide");
      issue(OP_PUSH, 2'b00, 3'd0, 32'h55, 5'd3, "R6 push imm");
      issue(OP_PUSH, 2'b01, 3'd0, 32'd4, 5'd3, "R6 push reg");
      issue(OP_POP, 2'b01, 3'd0, 32'd5, 5'd3, "R6 pop first");
      issue(OP_POP, 2'b01, 3'd0, 32'd2, 5'd3, "R6 pop second");
      issue(OP_LDR, 2'b00, 3'd4, 32'd5, 5'd4, "R5 load 5");
      issue(OP_CMP, 2'b00, 3'd4, 32'd3, 5'd3, "R4 cmp greater");
      issue(OP_JL, 2'b00, 3'd0, 32'h80, 5'd4, "R7 jl not taken");
      issue(OP_JZ, 2'b00, 3'd0, 32'h80, 5'd4, "R7 jz not taken");
      issue(OP_JG, 2'b00, 3'd0, 32'h90, 5'd4, "R7 jg taken");
      issue(OP_CMP, 2'b00, 3'd4, 32'd9, 5'd3, "R4 cmp less");
      issue(OP_JG, 2'b00, 3'd0, 32'h10, 5'd4, "R7 jg not taken");
      issue(OP_JL, 2'b00, 3'd0, 32'hA0, 5'd4, "R7 jl taken");
      issue(OP_CMP, 2'b00, 3'd4, 32'd5, 5'd3, "R4 cmp equal");
      issue(OP_JZ, 2'b01, 3'd0, 32'd2, 5'd4, "R7 jz taken reg target");
      issue(OP_JMP, 2'b00, 3'd0, 32'hC0, 5'd4, "R7 jmp");
      issue(OP_CALL, 2'b00, 3'd0, 32'h200, 5'd5, "R8 call");
      issue(OP_NOP, 2'b00, 3'd0, 32'd0, 5'd1, "R10 nop");
      issue(OP_RET, 2'b00, 3'd0, 32'd0, 5'd1, "R8 ret");
      issue(OP_LDR, 2'b00, 3'd0, 32'h300, 5'd6, "R10 ip write wins");
      for (int i = 0; i < 24; i++) begin
         op_e ops [9] = '{OP_ADD, OP_SUB, OP_MUL, OP_AND, OP_OR, OP_XOR, OP_SHL, OP_CMP, OP_DIV};
         op_e o = ops[$urandom_range(0, 8)];
         logic [31:0] v = $urandom;
         if (o == OP_SHL) v = v & 32'h1F;
         if (o == OP_DIV) v = v & 32'h3;
         issue(o, 2'b00, 3'($urandom_range(4, 5)), v, 5'($urandom_range(1, 16)), "R3 R4 mixed alu");
      end
      repeat (10) @(negedge clk);
      check(q.size() == 0, $sformatf("R11 one completion per record: got %0d pending expected 0", q.size()));
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule